// File: doc/BRIEF.md
# Prescaled Compare Timer Channel

This block is one up-counting timer channel. A slow reference tick arrives as a one-cycle enable on the system clock. A power-of-two prescaler divides that tick, and each prescaled tick advances a 16-bit counter. Two compare registers watch the counter. Compare A is a mid-interval marker: when the counter steps onto it, a flag is raised and counting goes on. Compare B is the terminal value: when the counter steps onto it, a flag is raised and the counter stops there. Each compare has its own two-bit event mode. The mode decides whether its flag is raised at all and whether the flag drives the interrupt output, the non-maskable output, or both.

Software reaches the channel through a four-word register window with a single write strobe and a combinational read port. The setup word holds the scale, the run bit, the two flags, the two event modes and a claim bit. The first write to the setup word fixes the scale and the modes and sets the claim bit. After that, software can only start or stop the counter and clear flags. A driver can therefore claim the channel once and then run it through repeated one-shot or periodic intervals: load the counter, start it, take the event, clear the flag, restart.

Top module: `prescaled_cmp_timer`

## Requirements
- R1: After reset, all four register words read 0 and `irqOut` and `nmiOut` are 0.
- R2: While running with scale s, the counter rises by exactly one for every 2^s reference ticks, counted from the cycle after start or after a counter load. The scale is setup bits [3:0]. A stored scale above 8 divides by 256 but still reads back as written.
- R3: The run bit is setup bit 4. While it is 0 the counter does not move. A setup write with bit 4 = 0 clears both flags, and the count stops in that same cycle.
- R4: A write to address 2 loads the counter, takes priority over a step in the same cycle, and restarts the prescaler phase.
- R5: Compare B is at address 1. When the counter steps onto it, the B flag (setup bit 6) sets and the counter holds that value until it is loaded or compare B changes.
- R6: Compare A is at address 0. When the counter steps onto it, the A flag (setup bit 5) sets and counting continues.
- R7: Writing 1 to setup bit 5 or bit 6 clears that flag. Writing 0 leaves it unchanged. Otherwise a flag stays set.
- R8: The B mode is setup bits [9:8] and the A mode is setup bits [11:10]. A mode of 0 prevents that flag from setting. In a nonzero mode, mode bit 0 routes the flag to `irqOut` and mode bit 1 routes it to `nmiOut`. Each output is the OR over both compares.
- R9: The first setup write stores the scale and both modes and sets the claim bit (setup bit 15). Later setup writes change only the run bit and clear flags.
- R10: Reads return compare A, compare B, the counter and the setup word at addresses 0 to 3. Setup bits 7 and [14:12] read 0.
- R11: The counter wraps from 0xFFFF to 0 and keeps counting toward compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 1 | One-cycle reference tick enable |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWdata | input | CNT_W | Write data |
| regRdata | output | CNT_W | Read data for `regAddr` |
| irqOut | output | 1 | Interrupt event output |
| nmiOut | output | 1 | Non-maskable event output |

## Verification
The counting path is run with a tick on every cycle and with a tick on every third cycle. This separates division of reference ticks from division of clock cycles. A scale sweep over 0, 3, 8 and an out-of-range 12 shows the exact power-of-two step rate and the clamp. Separate runs cover the terminal hold, a restart by load, a stop, wrap-around from 0xFFFE, and one-sided mode routing. These show whether flags set only on a step onto a compare, whether the hold releases only through a load, and whether the claim lock protects the scale and the modes. A behavioural reference model compares the outputs and the read word on every clock, so the ordering corner cases are covered as well: a load against a step, a stop against a hit, a clear against a set.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NUM_CMP = 2;
  localparam int SCALE_W = 4;
  localparam int TERM_IDX = 1;   // compare B is the terminal compare

  localparam logic [1:0] ADDR_CMPA  = 2'd0;
  localparam logic [1:0] ADDR_CMPB  = 2'd1;
  localparam logic [1:0] ADDR_CNT   = 2'd2;
  localparam logic [1:0] ADDR_SETUP = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic               cntLoad;
    logic [NUM_CMP-1:0] cmpLoad;
    logic               runEn;
  } tmrStrobes_t;

  // decoded fields of a setup write (index 0 = compare A, 1 = compare B)
  typedef struct packed {
    logic [SCALE_W-1:0]      scale;
    logic                    en;
    logic [NUM_CMP-1:0]      clr;
    logic [NUM_CMP-1:0][1:0] mode;
  } setupFields_t;
endpackage

// File: rtl/pct_ctrl.sv
module pct_ctrl
  import timer_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_SCALE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  setupFields_t       wrFields,
  input  logic [NUM_CMP-1:0] hits,
  output tmrStrobes_t        strb,
  output logic [SCALE_W-1:0] scaleEff,
  output logic [DATA_W-1:0]  setupWord,
  output logic               irqOut,
  output logic               nmiOut
);
  logic setupWr, stopWr, enQ, lockQ;
  logic [SCALE_W-1:0] scaleQ;
  logic [NUM_CMP-1:0][1:0] modeQ;
  logic [NUM_CMP-1:0] flagQ, irqTerm, nmiTerm;

  assign setupWr = regWe && (regAddr == ADDR_SETUP);
  assign stopWr  = setupWr && !wrFields.en;

  always_comb begin
    strb.runEn      = enQ && !stopWr;
    strb.cntLoad    = regWe && (regAddr == ADDR_CNT);
    strb.cmpLoad[0] = regWe && (regAddr == ADDR_CMPA);
    strb.cmpLoad[1] = regWe && (regAddr == ADDR_CMPB);
  end

  assign scaleEff = (scaleQ > SCALE_W'(MAX_SCALE)) ? SCALE_W'(MAX_SCALE) : scaleQ;

  // setup word: run bit always writable, other fields only until claimed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      lockQ  <= 1'b0;
      scaleQ <= '0;
      modeQ  <= '0;
    end else if (setupWr) begin
      enQ <= wrFields.en;
      if (!lockQ) begin
        scaleQ <= wrFields.scale;
        modeQ  <= wrFields.mode;
        lockQ  <= 1'b1;
      end
    end
  end

  // event flags: stop clears, hit sets, write-one clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (stopWr)
          flagQ[i] <= 1'b0;
        else if (hits[i] && (modeQ[i] != 2'b00))
          flagQ[i] <= 1'b1;
        else if (setupWr && wrFields.clr[i])
          flagQ[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : gEvt
    assign irqTerm[g] = flagQ[g] & modeQ[g][0];
    assign nmiTerm[g] = flagQ[g] & modeQ[g][1];

    // R7: a flag persists unless stopped or cleared by a write of one
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[g] && !stopWr && !(setupWr && wrFields.clr[g])) |=> flagQ[g]);
    // R8: a compare whose mode is off never holds a flag
    a_r8_mode_off: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[g] == 2'b00) |-> !flagQ[g]);
  end

  assign irqOut = |irqTerm;
  assign nmiOut = |nmiTerm;

  always_comb begin
    setupWord        = '0;
    setupWord[3:0]   = scaleQ;
    setupWord[4]     = enQ;
    setupWord[5]     = flagQ[0];
    setupWord[6]     = flagQ[1];
    setupWord[9:8]   = modeQ[1];
    setupWord[11:10] = modeQ[0];
    setupWord[15]    = lockQ;
  end

  // R9: once claimed, scale and modes are frozen and the claim stays
  a_r9_locked_fields: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ($stable(scaleQ) && $stable(modeQ) && lockQ));
  // R3: a stopping write leaves no pending flag
  a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (flagQ == '0));
endmodule

// File: rtl/pct_datapath.sv
module pct_datapath
  import timer_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_SCALE = 8,
  localparam int PRE_W    = (MAX_SCALE > 0) ? MAX_SCALE : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  tmrStrobes_t        strb,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [SCALE_W-1:0] scaleEff,
  input  logic [DATA_W-1:0]  setupWord,
  output logic [NUM_CMP-1:0] hits,
  output logic [DATA_W-1:0]  regRdata
);
  logic [PRE_W-1:0] preQ, preMask;
  logic [PRE_W:0] preSpan;
  logic preFull, atTerm, step;
  logic [DATA_W-1:0] cntQ, cntNext;
  logic [NUM_CMP-1:0][DATA_W-1:0] cmpQ;

  assign preSpan = (PRE_W+1)'(1) << scaleEff;
  assign preMask = PRE_W'(preSpan - (PRE_W+1)'(1));
  assign preFull = (preQ & preMask) == preMask;
  assign atTerm  = (cntQ == cmpQ[TERM_IDX]);
  assign step    = strb.runEn && refTick && preFull && !atTerm && !strb.cntLoad;
  assign cntNext = cntQ + DATA_W'(1);

  // prescaler phase: restarts whenever stopped or loaded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      preQ <= '0;
    else if (!strb.runEn || strb.cntLoad)
      preQ <= '0;
    else if (refTick)
      preQ <= preQ + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cntQ <= '0;
    else if (strb.cntLoad)
      cntQ <= regWdata;
    else if (step)
      cntQ <= cntNext;
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cmpQ[g] <= '0;
      else if (strb.cmpLoad[g])
        cmpQ[g] <= regWdata;
    end
    assign hits[g] = step && (cntNext == cmpQ[g]);
  end

  always_comb begin
    case (regAddr)
      ADDR_CMPA: regRdata = cmpQ[0];
      ADDR_CMPB: regRdata = cmpQ[1];
      ADDR_CNT:  regRdata = cntQ;
      default:   regRdata = setupWord;
    endcase
  end

  // R3: no movement while stopped and not loaded
  a_r3_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.runEn && !strb.cntLoad) |=> $stable(cntQ));
  // R5: the counter parks on the terminal compare
  a_r5_term_hold: assert property (@(posedge clk) disable iff (!rstN)
    (atTerm && !strb.cntLoad && !strb.cmpLoad[TERM_IDX]) |=> $stable(cntQ));
  // R4: a load lands the written value
  a_r4_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> (cntQ == $past(regWdata)));
  // R2, R11: any unloaded change is a single modular increment
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntLoad) |=> ($stable(cntQ) || (cntQ == DATA_W'($past(cntQ) + DATA_W'(1)))));
endmodule

// File: rtl/prescaled_cmp_timer.sv
module prescaled_cmp_timer
  import timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_SCALE = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  output logic             irqOut,
  output logic             nmiOut
);
  tmrStrobes_t        strb;
  setupFields_t       wrFields;
  logic [NUM_CMP-1:0] hits;
  logic [SCALE_W-1:0] scaleEff;
  logic [CNT_W-1:0]   setupWord;

  always_comb begin
    wrFields.scale   = regWdata[3:0];
    wrFields.en      = regWdata[4];
    wrFields.clr     = regWdata[6:5];
    wrFields.mode[0] = regWdata[11:10];
    wrFields.mode[1] = regWdata[9:8];
  end

  pct_ctrl #(.DATA_W(CNT_W), .MAX_SCALE(MAX_SCALE)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .wrFields(wrFields), .hits(hits), .strb(strb), .scaleEff(scaleEff),
    .setupWord(setupWord), .irqOut(irqOut), .nmiOut(nmiOut)
  );

  pct_datapath #(.DATA_W(CNT_W), .MAX_SCALE(MAX_SCALE)) uPath (
    .clk(clk), .rstN(rstN), .refTick(refTick), .strb(strb),
    .regAddr(regAddr), .regWdata(regWdata), .scaleEff(scaleEff),
    .setupWord(setupWord), .hits(hits), .regRdata(regRdata)
  );
endmodule

// File: tb/prescaled_cmp_timer_test.sv
module prescaled_cmp_timer_test;
  logic clk = 1'b0, rstN = 1'b0, refTick = 1'b0, regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic irqOut, nmiOut;
  int nChecks = 0, nFails = 0, tickMode = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int mCnt, mPre, mCmpA, mCmpB, mScale, mModeA, mModeB;
  bit mEn, mLock, mFa, mFb;

  always #4 clk = ~clk;   // 125 MHz

  prescaled_cmp_timer #(.CNT_W(16), .MAX_SCALE(8)) uut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .nmiOut(nmiOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mCmpA;
      2'd1: return mCmpB;
      2'd2: return mCnt;
      default: return mScale | (int'(mEn) << 4) | (int'(mFa) << 5) | (int'(mFb) << 6) |
                      (mModeB << 8) | (mModeA << 10) | (int'(mLock) << 15);
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    refTick = (tickMode == 0) ? 1'b1 : ((cyc % 3) == 0);
  end

  // behavioural model, compared on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mCmpA = 0; mCmpB = 0; mScale = 0; mModeA = 0; mModeB = 0;
      mEn = 0; mLock = 0; mFa = 0; mFb = 0;
    end else begin
      bit setupW, stopW, run, load, doStep, hitA, hitB;
      int nxt, period;
      setupW = regWe && regAddr == 2'd3;
      stopW  = setupW && !regWdata[4];
      run    = mEn && !stopW;
      load   = regWe && regAddr == 2'd2;
      period = 1 << ((mScale > 8) ? 8 : mScale);
      doStep = 0;
      if (!run || load) mPre = 0;
      else if (refTick) begin
        if (mPre == period - 1) begin
          mPre = 0;
          doStep = (mCnt != mCmpB);
        end else mPre++;
      end
      nxt  = (mCnt + 1) % 65536;
      hitA = doStep && nxt == mCmpA && mModeA != 0;
      hitB = doStep && nxt == mCmpB && mModeB != 0;
      if (load) mCnt = regWdata;
      else if (doStep) mCnt = nxt;
      if (stopW) begin mFa = 0; mFb = 0; end
      else begin
        if (setupW && regWdata[5]) mFa = 0;
        if (setupW && regWdata[6]) mFb = 0;
        if (hitA) mFa = 1;
        if (hitB) mFb = 1;
      end
      if (regWe && regAddr == 2'd0) mCmpA = regWdata;
      if (regWe && regAddr == 2'd1) mCmpB = regWdata;
      if (setupW) begin
        mEn = regWdata[4];
        if (!mLock) begin
          mScale = regWdata[3:0]; mModeB = regWdata[9:8]; mModeA = regWdata[11:10]; mLock = 1;
        end
      end
    end
    #2;
    check("R8 irq vs model", int'(irqOut), int'((mFa && mModeA[0]) || (mFb && mModeB[0])));
    check("R8 nmi vs model", int'(nmiOut), int'((mFa && mModeA[1]) || (mFb && mModeB[1])));
    check("R10 read vs model", int'(regRdata), modelRead(regAddr));
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk);
    regAddr = a;
    #1 d = int'(regRdata);
  endtask

  task automatic scaleRun(input logic [15:0] setup, input int n, input int exp, input string req);
    int v;
    doReset();
    wr(2'd1, 16'hFFFF);
    wr(2'd3, setup);
    repeat (n - 1) @(negedge clk);
    rd(2'd2, v);
    check(req, v, exp);
  endtask

  initial begin
    int v;
    doReset();
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reset read", v, 0);
    end
    check("R1 reset irq", int'(irqOut), 0);
    check("R1 reset nmi", int'(nmiOut), 0);

    // main interval: cmpA 5, cmpB 10, scale 1, modeB 3, modeA 1
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd10);
    rd(2'd0, v); check("R10 compare A readback", v, 5);
    rd(2'd1, v); check("R10 compare B readback", v, 10);
    wr(2'd3, 16'h0711);
    repeat (40) @(negedge clk);
    rd(2'd2, v); check("R5 counter holds at compare B", v, 10);
    rd(2'd3, v); check("R6 R9 setup with both flags", v, 16'h8771);
    check("R8 irq raised", int'(irqOut), 1);
    check("R8 nmi raised by B", int'(nmiOut), 1);

    // R9: claimed, only run bit and clears take effect; R7 clear A
    wr(2'd3, 16'h0030);
    rd(2'd3, v); check("R9 R7 locked fields, A cleared", v, 16'h8751);
    check("R8 irq still from B", int'(irqOut), 1);
    wr(2'd3, 16'h0010);
    rd(2'd3, v); check("R7 writing zero keeps B", v, 16'h8751);
    wr(2'd3, 16'h0050);
    rd(2'd3, v); check("R7 B cleared", v, 16'h8711);
    check("R8 irq low", int'(irqOut), 0);
    check("R8 nmi low", int'(nmiOut), 0);
    repeat (10) @(negedge clk);
    rd(2'd2, v); check("R5 still parked after clear", v, 10);

    // R4: reload restarts interval
    wr(2'd2, 16'd0);
    rd(2'd2, v); check("R4 load value", v, 0);
    repeat (30) @(negedge clk);
    rd(2'd3, v); check("R4 R5 interval repeats", v, 16'h8771);

    // R3: stop clears flags and freezes count
    wr(2'd3, 16'h0000);
    rd(2'd3, v); check("R3 stop clears flags", v, 16'h8701);
    check("R3 irq after stop", int'(irqOut), 0);
    wr(2'd2, 16'd2);
    repeat (20) @(negedge clk);
    rd(2'd2, v); check("R3 stopped count frozen", v, 2);

    // R2: scale sweep with a tick on every cycle
    scaleRun(16'h0010, 100, 100, "R2 scale 0");
    scaleRun(16'h0013, 100, 12, "R2 scale 3");
    scaleRun(16'h0018, 1000, 3, "R2 scale 8");
    scaleRun(16'h001C, 1000, 3, "R2 scale 12 clamped");
    rd(2'd3, v); check("R2 stored scale reads back", v & 16'hF, 12);

    // R2: sparse ticks, scale 2, 300 cycles, checked against the model
    tickMode = 1;
    scaleRun(16'h0012, 300, 25, "R2 sparse ticks");
    tickMode = 0;

    // R8: modeA off, modeB NMI only
    doReset();
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd6);
    wr(2'd3, 16'h0210);
    repeat (20) @(negedge clk);
    rd(2'd3, v); check("R8 A off, B nmi", v, 16'h8250);
    check("R8 irq not routed", int'(irqOut), 0);
    check("R8 nmi routed", int'(nmiOut), 1);

    // R11: wrap from 0xFFFE toward compare B of 3
    doReset();
    wr(2'd1, 16'd3);
    wr(2'd2, 16'hFFFE);
    wr(2'd3, 16'h0110);
    repeat (1) @(negedge clk);
    rd(2'd2, v); check("R11 wrapped to zero", v, 0);
    check("R11 no early irq", int'(irqOut), 0);
    repeat (10) @(negedge clk);
    rd(2'd2, v); check("R11 reaches compare B", v, 3);
    check("R11 irq at terminal", int'(irqOut), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule